// File: doc/BRIEF.md
# Phase-Error Lock Detector with Hysteresis

This block decides whether a phase-locked loop is locked by looking at the phase-detector pump pulses. A fast sampling clock counts how many of its cycles the pump-up or pump-down pulse is active between two reference-cycle strobes. That count is the phase error of one reference cycle. The count is judged against a small entry limit while hunting for lock and against a larger exit limit once locked, so the flag has hysteresis.

Entry into lock is qualified by a run of consecutive good cycles. The run is three cycles normally and five when the precision input is high. A single bad cycle while locked drops the flag. Tri-stating the charge pump, or powering down, forces the detector back to hunting at once and throws away any partial measurement. The pump pulses and the strobe are plain level inputs sampled on every clock. There is no data stream and no back-pressure: a strobe is always taken in the cycle it is presented.

Top module: `pll_lock_detect`

## Requirements
- R1: During and right after reset, `locked_o` is 0 and the run of good cycles is empty.
- R2: With `precise_i` low, `locked_o` rises after the third consecutive strobe whose error is below ENTRY_LIM (default 15 sampling cycles). The error is the number of sampling-clock edges since the previous strobe at which the pump was active.
- R3: While hunting, a strobe whose error is ENTRY_LIM or more empties the run, so three fresh good strobes are needed afterwards.
- R4: While locked, a strobe whose error is at most EXIT_LIM (default 30) keeps `locked_o` high, and one strobe with an error above EXIT_LIM drops it.
- R5: `cp_tristate_i` high forces `locked_o` to 0 at the next clock edge and empties both the run and the error accumulator.
- R6: `powerdown_i` high has the same forcing effect as `cp_tristate_i`.
- R7: With `precise_i` high, five consecutive good strobes are needed to raise `locked_o`.
- R8: When a strobe coincides with a forcing input, the forcing input wins and that strobe's measurement is discarded: it neither counts toward the run nor raises the flag.
- R9: The error count saturates at 2^ERR_W-1 (63 by default) and never wraps, so a very long pulse always reads as a large error.
- R10: `locked_o` changes only at the clock edge that samples a strobe or a forcing input; pump activity between strobes leaves it unchanged.
- R11: The pump-down pulse counts toward the error exactly as the pump-up pulse does. If both are high in the same sampling cycle, that cycle counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pump_up_i | input | 1 | Phase-detector pump-up pulse |
| pump_dn_i | input | 1 | Phase-detector pump-down pulse |
| ref_strobe_i | input | 1 | One-cycle marker closing each reference cycle |
| precise_i | input | 1 | Selects the five-cycle entry run |
| cp_tristate_i | input | 1 | Charge pump tri-stated; forces unlock |
| powerdown_i | input | 1 | Powerdown state; forces unlock |
| locked_o | output | 1 | Registered lock flag |

## Verification
The collision that matters is a reference strobe that falls in the same cycle as a tri-state or powerdown request. The bench builds up two good cycles and then raises the third strobe together with the tri-state input. The flag must stay low, and the next three good strobes must be needed to lock again, which shows the colliding measurement was discarded rather than counted. The same kind of judgement applies where an exit-size error reaches a strobe while the run logic is idle in the locked state: only the threshold decides the outcome.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;

  typedef enum logic {
    LD_HUNT   = 1'b0,
    LD_LOCKED = 1'b1
  } ld_state_e;

  // Saturating increment for the error accumulator.
  function automatic logic [15:0] sat_inc(input logic [15:0] val, input logic [15:0] max_val,
                                          input logic step);
    if (!step) return val;
    if (val >= max_val) return max_val;
    return val + 16'd1;
  endfunction

endpackage

// File: rtl/pll_ld_err_meter.sv
module pll_ld_err_meter #(
  parameter int ERR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pump_up_i,
  input  logic             pump_dn_i,
  input  logic             strobe_i,
  input  logic             flush_i,
  output logic [ERR_W-1:0] err_o,
  output logic             err_vld_o
);
  import pll_ld_pkg::*;

  localparam int unsigned ERR_MAX = (1 << ERR_W) - 1;

  logic [ERR_W-1:0] acc_q;
  logic [15:0]      next_wide;
  logic             active;

  // Either pump direction is phase error; an overlap counts once.
  assign active    = pump_up_i | pump_dn_i;
  assign next_wide = sat_inc(16'(acc_q), 16'(ERR_MAX), active);
  assign err_o     = next_wide[ERR_W-1:0];
  assign err_vld_o = strobe_i & ~flush_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (strobe_i || flush_i) begin
      acc_q <= '0;
    end else begin
      acc_q <= next_wide[ERR_W-1:0];
    end
  end

endmodule

// File: rtl/pll_ld_classify.sv
module pll_ld_classify #(
  parameter int ERR_W     = 6,
  parameter int ENTRY_LIM = 15,
  parameter int EXIT_LIM  = 30
) (
  input  logic [ERR_W-1:0] err_i,
  output logic             good_o,
  output logic             bad_o
);
  localparam logic [ERR_W-1:0] ENTRY_V = ERR_W'(ENTRY_LIM);
  localparam logic [ERR_W-1:0] EXIT_V  = ERR_W'(EXIT_LIM);

  assign good_o = (err_i < ENTRY_V);
  assign bad_o  = (err_i > EXIT_V);

endmodule

// File: rtl/pll_ld_run_fsm.sv
module pll_ld_run_fsm #(
  parameter int COARSE_RUNS = 3,
  parameter int FINE_RUNS   = 5,
  parameter int RUN_W       = $clog2(FINE_RUNS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_i,
  input  logic             meas_vld_i,
  input  logic             good_i,
  input  logic             bad_i,
  input  logic             precise_i,
  output logic [RUN_W-1:0] run_o,
  output logic             locked_o
);
  import pll_ld_pkg::*;

  localparam logic [RUN_W-1:0] NEED_COARSE = RUN_W'(COARSE_RUNS);
  localparam logic [RUN_W-1:0] NEED_FINE   = RUN_W'(FINE_RUNS);

  ld_state_e        state_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] need;
  logic [RUN_W-1:0] run_inc;

  assign need    = precise_i ? NEED_FINE : NEED_COARSE;
  assign run_inc = run_q + RUN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LD_HUNT;
      run_q   <= '0;
    end else if (force_i) begin
      state_q <= LD_HUNT;
      run_q   <= '0;
    end else if (meas_vld_i) begin
      unique case (state_q)
        LD_HUNT: begin
          if (!good_i) begin
            run_q <= '0;
          end else if (run_inc >= need) begin
            state_q <= LD_LOCKED;
            run_q   <= '0;
          end else begin
            run_q <= run_inc;
          end
        end
        LD_LOCKED: begin
          if (bad_i) state_q <= LD_HUNT;
          run_q <= '0;
        end
        default: begin
          state_q <= LD_HUNT;
          run_q   <= '0;
        end
      endcase
    end
  end

  assign run_o    = run_q;
  assign locked_o = (state_q == LD_LOCKED);

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int ERR_W       = 6,
  parameter int ENTRY_LIM   = 15,
  parameter int EXIT_LIM    = 30,
  parameter int COARSE_RUNS = 3,
  parameter int FINE_RUNS   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pump_up_i,
  input  logic pump_dn_i,
  input  logic ref_strobe_i,
  input  logic precise_i,
  input  logic cp_tristate_i,
  input  logic powerdown_i,
  output logic locked_o
);
  localparam int RUN_W = $clog2(FINE_RUNS + 1);

  logic             force_w;
  logic [ERR_W-1:0] err_w;
  logic             meas_vld_w;
  logic             good_w;
  logic             bad_w;
  logic [RUN_W-1:0] run_w;

  assign force_w = cp_tristate_i | powerdown_i;

  pll_ld_err_meter #(.ERR_W(ERR_W)) meter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pump_up_i (pump_up_i),
    .pump_dn_i (pump_dn_i),
    .strobe_i  (ref_strobe_i),
    .flush_i   (force_w),
    .err_o     (err_w),
    .err_vld_o (meas_vld_w)
  );

  pll_ld_classify #(
    .ERR_W(ERR_W), .ENTRY_LIM(ENTRY_LIM), .EXIT_LIM(EXIT_LIM)
  ) classify_i (
    .err_i  (err_w),
    .good_o (good_w),
    .bad_o  (bad_w)
  );

  pll_ld_run_fsm #(
    .COARSE_RUNS(COARSE_RUNS), .FINE_RUNS(FINE_RUNS), .RUN_W(RUN_W)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_i    (force_w),
    .meas_vld_i (meas_vld_w),
    .good_i     (good_w),
    .bad_i      (bad_w),
    .precise_i  (precise_i),
    .run_o      (run_w),
    .locked_o   (locked_o)
  );

endmodule

// File: rtl/pll_ld_checker.sv
module pll_ld_checker #(
  parameter int ERR_W     = 6,
  parameter int EXIT_LIM  = 30,
  parameter int FINE_RUNS = 5,
  parameter int RUN_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_strobe_i,
  input logic             cp_tristate_i,
  input logic             powerdown_i,
  input logic             locked_o,
  input logic [ERR_W-1:0] err_w,
  input logic [RUN_W-1:0] run_w
);
  logic frc;
  assign frc = cp_tristate_i | powerdown_i;

  assert_tristate_unlocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cp_tristate_i |=> !locked_o);

  assert_powerdown_unlocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    powerdown_i |=> !locked_o);

  assert_quiet_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_strobe_i && !frc) |=> $stable(locked_o));

  assert_rise_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && !(ref_strobe_i && !frc)) |=> !locked_o);

  assert_hold_small_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && ref_strobe_i && !frc && (err_w <= ERR_W'(EXIT_LIM))) |=> locked_o);

  assert_exit_large_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && ref_strobe_i && (err_w > ERR_W'(EXIT_LIM))) |=> !locked_o);

  assert_run_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_w < RUN_W'(FINE_RUNS));

  assert_run_empty_when_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> (run_w == '0));

endmodule

bind pll_lock_detect pll_ld_checker #(
  .ERR_W(ERR_W), .EXIT_LIM(EXIT_LIM), .FINE_RUNS(FINE_RUNS), .RUN_W(RUN_W)
) checker_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ref_strobe_i  (ref_strobe_i),
  .cp_tristate_i (cp_tristate_i),
  .powerdown_i   (powerdown_i),
  .locked_o      (locked_o),
  .err_w         (err_w),
  .run_w         (run_w)
);

// File: tb/pll_lock_detect_tb.sv
module pll_lock_detect_tb_top;
  localparam time HALF = 4ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, dn = 1'b0, stb = 1'b0, prec = 1'b0, tri_s = 1'b0, pdn = 1'b0;
  logic locked;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];
  logic  expect_now = 1'b0;
  logic  took = 1'b0;

  always #HALF clk = ~clk;

  pll_lock_detect dut_i (
    .clk(clk), .rst_n(rst_n), .pump_up_i(up), .pump_dn_i(dn), .ref_strobe_i(stb),
    .precise_i(prec), .cp_tristate_i(tri_s), .powerdown_i(pdn), .locked_o(locked)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: locked_o=%b expected=%b", req, act, exp);
    end
  endtask

  // Monitor: compare one queued item after each edge that took a strobe or force.
  always @(posedge clk) took <= expect_now;
  always @(negedge clk) begin
    if (took && exp_q.size() > 0) begin
      check(locked, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  // Driver tasks
  task automatic pulse(input int w, input bit use_dn, input bit both);
    for (int i = 0; i < w; i++) begin
      @(posedge clk); #1;
      up = !use_dn || both;
      dn = use_dn || both;
    end
    @(posedge clk); #1;
    up = 1'b0; dn = 1'b0;
  endtask

  task automatic strobe(input bit f_tri, input bit exp, input string tag);
    @(posedge clk); #1;
    stb = 1'b1; tri_s = f_tri; expect_now = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    stb = 1'b0; tri_s = 1'b0; expect_now = 1'b0;
  endtask

  task automatic cycle(input int w, input bit exp, input string tag);
    pulse(w, 1'b0, 1'b0);
    strobe(1'b0, exp, tag);
  endtask

  task automatic force_it(input bit use_pd, input string tag);
    @(posedge clk); #1;
    if (use_pd) pdn = 1'b1; else tri_s = 1'b1;
    expect_now = 1'b1;
    exp_q.push_back(1'b0); tag_q.push_back(tag);
    @(posedge clk); #1;
    pdn = 1'b0; tri_s = 1'b0; expect_now = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(locked, 1'b0, "R1 reset");
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(locked, 1'b0, "R1 after reset");

    // R2: three good cycles lock
    cycle(5, 1'b0, "R2 run1");
    cycle(0, 1'b0, "R2 run2");
    cycle(14, 1'b1, "R2 run3");

    // R4: exactly EXIT_LIM holds, above drops; R10 flag steady before strobe
    cycle(30, 1'b1, "R4 hold at 30");
    cycle(20, 1'b1, "R4 hold at 20");
    pulse(31, 1'b0, 1'b0);
    @(negedge clk);
    check(locked, 1'b1, "R10 no change before strobe");
    strobe(1'b0, 1'b0, "R4 exit at 31");

    // R3: error of 15 empties the run
    cycle(14, 1'b0, "R3 good1");
    cycle(14, 1'b0, "R3 good2");
    cycle(15, 1'b0, "R3 bad at 15");
    cycle(14, 1'b0, "R3 fresh1");
    cycle(14, 1'b0, "R3 fresh2");
    cycle(14, 1'b1, "R3 fresh3 locks");

    // R5: tri-state forces unlock and empties the run
    force_it(1'b0, "R5 tristate unlock");
    cycle(2, 1'b0, "R5 relock1");
    cycle(2, 1'b0, "R5 relock2");
    // R6: powerdown with partial run, run must restart
    force_it(1'b1, "R6 powerdown unlock");
    cycle(2, 1'b0, "R6 restart1");
    cycle(2, 1'b0, "R6 restart2");
    cycle(2, 1'b1, "R6 restart3 locks");

    // R9: 70-cycle error saturates, never wraps to 6
    cycle(70, 1'b0, "R9 saturating exit");

    // R8: strobe coincides with tri-state
    cycle(3, 1'b0, "R8 good1");
    cycle(3, 1'b0, "R8 good2");
    pulse(3, 1'b0, 1'b0);
    strobe(1'b1, 1'b0, "R8 force wins");
    cycle(3, 1'b0, "R8 after1");
    cycle(3, 1'b0, "R8 after2");
    cycle(3, 1'b1, "R8 after3 locks");

    // R7 and R11: precision run with down and overlapping pulses
    force_it(1'b0, "R7 start unlocked");
    @(posedge clk); #1 prec = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      pulse(7, 1'b1, (k == 2));
      strobe(1'b0, 1'b0, "R7 fine run below five");
    end
    pulse(7, 1'b1, 1'b0);
    strobe(1'b0, 1'b1, "R7 fifth locks");
    // R11: down pulse over the exit limit drops lock
    pulse(31, 1'b1, 1'b0);
    strobe(1'b0, 1'b0, "R11 down pulse exit");
    // R11: overlapping up/down counts once (16 -> not good)
    pulse(16, 1'b0, 1'b1);
    strobe(1'b0, 1'b0, "R11 overlap 16 bad");
    for (int k = 0; k < 4; k++) begin
      pulse(8, 1'b0, 1'b1);
      strobe(1'b0, 1'b0, "R11 overlap 8 good");
    end
    pulse(8, 1'b0, 1'b1);
    strobe(1'b0, 1'b1, "R11 overlap fifth locks");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule